// File: doc/BRIEF.md
# Transmit Descriptor Ring Post Engine

This block keeps the producer and consumer indices for a set of egress descriptor rings. Software adds descriptors with a memory-mapped store. The store names the ring in the address and carries three things in its data: the tail index as it stood before the store, the number of new descriptors, and a generation bit. The block works out the new tail, masked to that ring's power-of-two size, and raises a per-ring fetch request. The request stays up until the descriptor fetcher has consumed everything.

The fetcher itself lies outside the block. It is modelled by three pulse inputs. A head-advance pulse consumes one descriptor. An idle pulse reports that a wake-up probe found nothing. A completion pulse reports one finished descriptor. A memory-mapped load returns, one cycle later, the ring's head index, a rolling count of completed descriptors, and the current generation bit. A small configuration port sets each ring's size and its flush bit. When the flush bit is cleared, the ring's completion count returns to zero.

Top module: `txring_post_engine`

## Requirements
- R1: A store or load acts only when address bits 28:26 equal 5, and the ring is chosen by address bits 8:3. A store with any other region value changes no ring state and raises no request.
- R2: An accepted store sets the ring's tail to (data[15:0] + data[31:16]) masked to the ring size. From the next cycle, fetch_req for that ring is high while head differs from tail.
- R3: A store whose old tail plus count passes the end of the ring wraps. For example, old tail 14 plus count 5 on a 16-entry ring gives tail 3.
- R4: A store whose count equals the ring size leaves the tail unchanged but keeps fetch_req high until the head has advanced a full ring and returned to the tail.
- R5: A store with count 0 raises fetch_req on the next cycle even when head equals tail. An idle pulse for that ring then drops the request.
- R6: A head-advance pulse on a requesting ring moves the head by one, masked to the ring size. fetch_req drops in the cycle after the head reaches the tail. An advance on a ring that is not requesting is ignored.
- R7: The generation bit starts at 0 and toggles each time the head wraps to index 0.
- R8: Every load gives rd_valid exactly one cycle later. For an accepted load, rd_data holds the head in bits 15:0, the completion count in bits 31:16, the generation in bit 32, and zeros above. A load with a wrong region returns all zeros.
- R9: Each completion pulse adds one to that ring's completion count.
- R10: A configuration write that changes the flush bit from 1 to 0 clears that ring's completion count. Setting the flush bit keeps the count.
- R11: A configuration write sets the ring's size to 2^cfg_log2 (default 16). Each ring masks its indices with its own size.
- R12: After reset, every head, tail, count and generation is 0 and fetch_req is all zeros.
- R13: On stores, data bit 32 and bits 63:33 have no effect on ring state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmio_valid | input | 1 | Memory-mapped access this cycle |
| mmio_write | input | 1 | 1 = store (post), 0 = load (status) |
| mmio_addr | input | 32 | Access address: region in 28:26, ring in 8:3 |
| mmio_wdata | input | 64 | Store data: old tail 15:0, count 31:16 |
| rd_valid | output | 1 | Load response valid |
| rd_data | output | 64 | Load response: head, completion count, generation |
| fetch_req | output | 64 | Per-ring request to the descriptor fetcher |
| adv_valid | input | 1 | Fetcher consumed one descriptor |
| adv_ring | input | 6 | Ring of the head advance |
| idle_valid | input | 1 | Fetcher found no valid descriptor |
| idle_ring | input | 6 | Ring of the idle report |
| done_valid | input | 1 | One descriptor completed |
| done_ring | input | 6 | Ring of the completion |
| cfg_valid | input | 1 | Configuration write |
| cfg_ring | input | 6 | Ring being configured |
| cfg_log2 | input | 4 | log2 of the ring size |
| cfg_flush | input | 1 | New flush bit value |

## Verification
Posts are tried in four shapes:
- A short post that stays inside the ring, which shows the basic tail arithmetic.
- A post that crosses the wrap point, where an unmasked sum would give a different tail and the head must flip the generation.
- A post of a whole ring, where head equals tail but work is pending, which separates a plain index comparison from the wake flag.
- A zero-count post, which must request a fetch with nothing new.

A ring resized to 8 entries and posted from slot 6 tells per-ring masking apart from a global size. Stores and loads with a foreign region, and stores with junk in the high data bits, show that those inputs are ignored. Completion pulses around a flush set and clear show that only the falling flush bit zeroes the count.

// File: rtl/txring_pkg.sv
package txring_pkg;
    parameter int NUM_RINGS   = 64;
    parameter int RING_W      = $clog2(NUM_RINGS);
    parameter int IDX_W       = 16;
    parameter int CNT_W       = 16;
    parameter int LOG2_W      = 4;
    parameter int ADDR_W      = 32;
    parameter int DATA_W      = 64;
    parameter int RING_LO     = 3;
    parameter int REGION_LO   = 26;
    parameter int REGION_W    = 3;
    parameter int POST_REGION = 5;
    parameter int GEN_BIT     = IDX_W + CNT_W;
    parameter int DEF_LOG2    = 4;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [LOG2_W-1:0] log2_t;
    typedef logic [RING_W-1:0] ring_id_t;

    typedef struct packed {
        idx_t  head;
        idx_t  tail;
        cnt_t  done_cnt;
        log2_t lg;
        logic  gen;
        logic  wake;
        logic  flush;
    } ring_t;
endpackage

// File: rtl/txring_decode.sv
module txring_decode
    import txring_pkg::*;
(
    input  logic              mmio_valid,
    input  logic              mmio_write,
    input  logic [ADDR_W-1:0] mmio_addr,
    input  logic [DATA_W-1:0] mmio_wdata,
    output logic              hit,
    output ring_id_t          ring,
    output logic              post_en,
    output logic              load_en,
    output idx_t              post_old,
    output cnt_t              post_cnt
);
    logic region_ok;
    logic unused_bits;

    assign region_ok = (mmio_addr[REGION_LO +: REGION_W] == REGION_W'(POST_REGION));
    assign hit       = region_ok;
    assign ring      = mmio_addr[RING_LO +: RING_W];
    assign post_en   = mmio_valid &&  mmio_write && region_ok;
    assign load_en   = mmio_valid && !mmio_write;
    assign post_old  = mmio_wdata[IDX_W-1:0];
    assign post_cnt  = mmio_wdata[IDX_W +: CNT_W];

    // store generation and upper data bits carry no state in this block
    assign unused_bits = ^{mmio_wdata[DATA_W-1:GEN_BIT], mmio_addr[ADDR_W-1:REGION_LO+REGION_W],
                           mmio_addr[REGION_LO-1:RING_LO+RING_W], mmio_addr[RING_LO-1:0]};
endmodule

// File: rtl/txring_slot.sv
module txring_slot
    import txring_pkg::*;
#(
    parameter int RESET_LOG2 = DEF_LOG2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  post_en,
    input  idx_t  post_old,
    input  cnt_t  post_cnt,
    input  logic  adv_en,
    input  logic  idle_en,
    input  logic  done_en,
    input  logic  cfg_en,
    input  log2_t cfg_lg,
    input  logic  cfg_flush,
    output ring_t state_o,
    output logic  req_o
);
    ring_t          s_d, s_q;
    idx_t           mask;
    logic [IDX_W:0] size;
    idx_t           head_n, tail_n;
    logic           wake_set, wake_clr, adv_ok;

    assign req_o   = (s_q.head != s_q.tail) || s_q.wake;
    assign state_o = s_q;

    always_comb begin
        s_d      = s_q;
        mask     = ~(idx_t'('1) << s_q.lg);
        size     = (IDX_W+1)'(1) << s_q.lg;
        adv_ok   = adv_en && req_o;
        head_n   = s_q.head;
        tail_n   = s_q.tail;

        if (adv_ok) begin
            head_n = idx_t'(s_q.head + 1'b1) & mask;
            if (head_n == '0) begin
                s_d.gen = ~s_q.gen;
            end
        end
        if (post_en) begin
            tail_n = idx_t'(post_old + post_cnt) & mask;
        end

        wake_set = post_en && ((post_cnt == '0) || ((IDX_W+1)'(post_cnt) == size));
        wake_clr = idle_en || (adv_ok && (head_n == tail_n));
        s_d.wake = wake_set || (s_q.wake && !wake_clr);
        s_d.head = head_n;
        s_d.tail = tail_n;

        if (cfg_en && s_q.flush && !cfg_flush) begin
            s_d.done_cnt = '0;
        end else if (done_en) begin
            s_d.done_cnt = cnt_t'(s_q.done_cnt + 1'b1);
        end

        if (cfg_en) begin
            s_d.lg    = cfg_lg;
            s_d.flush = cfg_flush;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.lg <= LOG2_W'(RESET_LOG2);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/txring_post_engine.sv
module txring_post_engine
    import txring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mmio_valid,
    input  logic                 mmio_write,
    input  logic [ADDR_W-1:0]    mmio_addr,
    input  logic [DATA_W-1:0]    mmio_wdata,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_RINGS-1:0] fetch_req,
    input  logic                 adv_valid,
    input  logic [RING_W-1:0]    adv_ring,
    input  logic                 idle_valid,
    input  logic [RING_W-1:0]    idle_ring,
    input  logic                 done_valid,
    input  logic [RING_W-1:0]    done_ring,
    input  logic                 cfg_valid,
    input  logic [RING_W-1:0]    cfg_ring,
    input  logic [LOG2_W-1:0]    cfg_log2,
    input  logic                 cfg_flush
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    logic     hit, post_en, load_en;
    ring_id_t ring;
    idx_t     post_old;
    cnt_t     post_cnt;
    ring_t    st [NUM_RINGS];
    rsp_t     rsp_d, rsp_q;

    txring_decode u_decode (
        .mmio_valid (mmio_valid),
        .mmio_write (mmio_write),
        .mmio_addr  (mmio_addr),
        .mmio_wdata (mmio_wdata),
        .hit        (hit),
        .ring       (ring),
        .post_en    (post_en),
        .load_en    (load_en),
        .post_old   (post_old),
        .post_cnt   (post_cnt)
    );

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        txring_slot #(.RESET_LOG2(DEF_LOG2)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .post_en   (post_en && (ring == ring_id_t'(r))),
            .post_old  (post_old),
            .post_cnt  (post_cnt),
            .adv_en    (adv_valid && (adv_ring == ring_id_t'(r))),
            .idle_en   (idle_valid && (idle_ring == ring_id_t'(r))),
            .done_en   (done_valid && (done_ring == ring_id_t'(r))),
            .cfg_en    (cfg_valid && (cfg_ring == ring_id_t'(r))),
            .cfg_lg    (cfg_log2),
            .cfg_flush (cfg_flush),
            .state_o   (st[r]),
            .req_o     (fetch_req[r])
        );
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = load_en;
        if (load_en && hit) begin
            rsp_d.data = DATA_W'({st[ring].gen, st[ring].done_cnt, st[ring].head});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_valid = rsp_q.valid;
    assign rd_data  = rsp_q.data;
endmodule

// File: rtl/txring_post_chk.sv
module txring_post_chk
    import txring_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mmio_valid,
    input logic                 mmio_write,
    input logic [ADDR_W-1:0]    mmio_addr,
    input logic [DATA_W-1:0]    mmio_wdata,
    input logic                 rd_valid,
    input logic [DATA_W-1:0]    rd_data,
    input logic [NUM_RINGS-1:0] fetch_req,
    input logic                 adv_valid,
    input logic                 idle_valid
);
    logic good_region;
    logic store_any;
    assign good_region = (mmio_addr[REGION_LO +: REGION_W] == REGION_W'(POST_REGION));
    assign store_any   = mmio_valid && mmio_write;

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_valid && !mmio_write) |=> rd_valid); // R8

    AST_RD_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        !(mmio_valid && !mmio_write) |=> !rd_valid); // R8

    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[DATA_W-1:GEN_BIT+1] == '0)); // R8

    AST_WAKE_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (store_any && good_region && (mmio_wdata[IDX_W +: CNT_W] == '0))
        |=> fetch_req[$past(mmio_addr[RING_LO +: RING_W])]); // R5

    AST_FOREIGN_REGION_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (store_any && !good_region && !adv_valid && !idle_valid) |=> $stable(fetch_req)); // R1

    AST_REQ_HOLDS_WITHOUT_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_any && !adv_valid && !idle_valid) |=> $stable(fetch_req)); // R6
endmodule

bind txring_post_engine txring_post_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mmio_valid (mmio_valid),
    .mmio_write (mmio_write),
    .mmio_addr  (mmio_addr),
    .mmio_wdata (mmio_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .fetch_req  (fetch_req),
    .adv_valid  (adv_valid),
    .idle_valid (idle_valid)
);

// File: tb/txring_post_engine_bench.sv
module txring_post_engine_bench;
    import txring_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 mmio_valid = 1'b0, mmio_write = 1'b0;
    logic [ADDR_W-1:0]    mmio_addr = '0;
    logic [DATA_W-1:0]    mmio_wdata = '0;
    logic                 rd_valid;
    logic [DATA_W-1:0]    rd_data;
    logic [NUM_RINGS-1:0] fetch_req;
    logic                 adv_valid = 1'b0, idle_valid = 1'b0, done_valid = 1'b0, cfg_valid = 1'b0;
    logic [RING_W-1:0]    adv_ring = '0, idle_ring = '0, done_ring = '0, cfg_ring = '0;
    logic [LOG2_W-1:0]    cfg_log2 = '0;
    logic                 cfg_flush = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];

    always #2 clk = ~clk;

    txring_post_engine u_txring_post_engine (.*);

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(int ring, int region);
        return ADDR_W'(region) << REGION_LO | ADDR_W'(ring) << RING_LO;
    endfunction

    task automatic post(int ring, int old_t, int cnt, int region = POST_REGION,
                        logic [DATA_W-1:0] high = '0);
        @(negedge clk);
        mmio_valid = 1; mmio_write = 1; mmio_addr = mk_addr(ring, region);
        mmio_wdata = high | (DATA_W'(cnt) << IDX_W) | DATA_W'(old_t);
        @(negedge clk);
        mmio_valid = 0; mmio_write = 0;
    endtask

    task automatic load(int ring, logic [DATA_W-1:0] exp, string tag, int region = POST_REGION);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        mmio_valid = 1; mmio_write = 0; mmio_addr = mk_addr(ring, region);
        @(negedge clk);
        mmio_valid = 0;
    endtask

    task automatic adv(int ring, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); adv_valid = 1; adv_ring = RING_W'(ring);
            @(negedge clk); adv_valid = 0;
        end
    endtask

    task automatic idle(int ring);
        @(negedge clk); idle_valid = 1; idle_ring = RING_W'(ring);
        @(negedge clk); idle_valid = 0;
    endtask

    task automatic done(int ring, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); done_valid = 1; done_ring = RING_W'(ring);
            @(negedge clk); done_valid = 0;
        end
    endtask

    task automatic cfg(int ring, int lg, logic fl);
        @(negedge clk); cfg_valid = 1; cfg_ring = RING_W'(ring); cfg_log2 = LOG2_W'(lg); cfg_flush = fl;
        @(negedge clk); cfg_valid = 0;
    endtask

    // monitor: pop expected read responses as they appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected response", rd_data, '1);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(4 * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    localparam logic [DATA_W-1:0] G1 = DATA_W'(1) << GEN_BIT;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12 fetch_req after reset", DATA_W'(fetch_req), '0);
        load(0, '0, "R12 ring 0 state after reset");

        // short post inside the ring
        post(1, 0, 3);
        check("R2 request after post", DATA_W'(fetch_req[1]), 1);
        load(1, '0, "R2 head still 0");
        adv(1, 2);
        check("R6 request while head behind", DATA_W'(fetch_req[1]), 1);
        adv(1, 1);
        check("R6 request drops at tail", DATA_W'(fetch_req[1]), 0);
        adv(1, 1);
        load(1, 64'd3, "R6 head 3, extra advance ignored");

        // post across the wrap point
        post(2, 0, 14);
        adv(2, 14);
        check("R6 ring 2 drained", DATA_W'(fetch_req[2]), 0);
        post(2, 14, 5);
        check("R3 wrapped post requests", DATA_W'(fetch_req[2]), 1);
        adv(2, 2);
        load(2, G1, "R7 gen toggles at head wrap");
        adv(2, 3);
        check("R3 wrapped tail is 3", DATA_W'(fetch_req[2]), 0);
        load(2, G1 | 64'd3, "R3 head reaches 3");

        // whole-ring post
        post(3, 0, 16);
        check("R4 full post requests", DATA_W'(fetch_req[3]), 1);
        adv(3, 15);
        check("R4 still requesting after 15", DATA_W'(fetch_req[3]), 1);
        adv(3, 1);
        check("R4 drops after full ring", DATA_W'(fetch_req[3]), 0);
        load(3, G1, "R7 gen after full ring");

        // zero-count wake
        post(4, 0, 0);
        check("R5 wake request", DATA_W'(fetch_req[4]), 1);
        idle(4);
        check("R5 idle clears wake", DATA_W'(fetch_req[4]), 0);

        // per-ring size
        cfg(5, 3, 0);
        post(5, 6, 4);
        adv(5, 2);
        check("R11 size-8 tail is 2", DATA_W'(fetch_req[5]), 0);
        load(5, 64'd2, "R11 head 2");

        // region decode
        post(6, 0, 2, 4);
        check("R1 foreign region store ignored", DATA_W'(fetch_req), '0);
        post(7, 0, 1);
        check("R1 ring select bits 8:3", DATA_W'(fetch_req), 64'h80);
        load(6, '0, "R1 ring 6 untouched");
        load(1, '0, "R8 foreign region load reads zero", 3);

        // completions and flush
        done(8, 5);
        load(8, 64'd5 << IDX_W, "R9 five completions");
        cfg(8, 4, 1);
        done(8, 2);
        load(8, 64'd7 << IDX_W, "R10 setting flush keeps count");
        cfg(8, 4, 0);
        load(8, '0, "R10 clearing flush zeroes count");

        // junk in high store bits
        post(9, 1, 1, POST_REGION, {31'h7fff_ffff, 1'b1, 32'h0});
        check("R13 post with high bits requests", DATA_W'(fetch_req[9]), 1);
        load(9, '0, "R13 gen and head unaffected");

        repeat (4) @(negedge clk);
        check("R8 all responses seen", DATA_W'(exp_q.size()), 0);
        summary();
    end
endmodule